// File: doc/BRIEF.md
# SHA-512 Message Schedule Helper

This block produces four new SHA-512 message-schedule words at a time. It works in two steps, and a one-bit operation select chooses the step. The expand step adds the small sigma0 of the following word to each of four consecutive schedule words. The finish step completes four words by adding small sigma1 terms. In the finish step, the upper two lanes take their sigma1 input from the lower two lanes of the result being computed, so the lanes form a chain.

Both operands are 256 bits wide and hold four 64-bit lanes. Lane i occupies bits [64i+63:64i]. The expand step uses all of operand A and only lane 0 of operand B. The finish step uses all of operand A and lanes 2 and 3 of operand B. The caller adds the W[t-7] term between the two steps and adds the round constants. The result is held in an output register with its own valid flag.

Top module: `msched_top`

## Requirements
- R1: With op_sel = 0 (expand), result lane i for i = 0, 1, 2 equals A lane i plus s0(A lane i+1), where s0(x) = rotr(x,1) ^ rotr(x,8) ^ (x >> 7).
- R2: With op_sel = 0, result lane 3 equals A lane 3 plus s0(B lane 0), and B lanes 1 to 3 have no effect on the result.
- R3: With op_sel = 1 (finish), result lanes 0 and 1 equal A lane 0 plus s1(B lane 2) and A lane 1 plus s1(B lane 3), where s1(x) = rotr(x,19) ^ rotr(x,61) ^ (x >> 6).
- R4: With op_sel = 1, result lane 2 equals A lane 2 plus s1(result lane 0), and result lane 3 equals A lane 3 plus s1(result lane 1).
- R5: With op_sel = 1, B lanes 0 and 1 have no effect on the result.
- R6: Every lane sum wraps modulo 2^64, and no carry passes from one lane into the next.
- R7: The result and out_valid appear one clock after the accepted input. out_valid is high exactly in the cycle after a cycle with in_valid high.
- R8: A synchronous reset clears out_valid and the result register to zero.
- R9: While in_valid is low, the result register keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and op_sel are valid this cycle |
| op_sel | input | 1 | Step select: 0 = expand, 1 = finish |
| opnd_a | input | 256 | Operand A, four 64-bit lanes |
| opnd_b | input | 256 | Operand B, four 64-bit lanes |
| out_valid | output | 1 | Result is valid |
| result | output | 256 | Four 64-bit result lanes |

## Verification
The hardest case to reach from the ports is the finish-step chain. Random-looking operands alone cannot show that lanes 2 and 3 take their input from the computed lanes 0 and 1 and not from any operand lane. The stimulus sets A lanes 0 and 1 to zero and makes B lane 2 a single set bit. The sigma1 of lane 0 then has a hand-derived pattern in which two rotated copies cancel, so a lane wired to the wrong source gives a visibly different value. The bench also checks that the operand lanes each step ignores are truly ignored. It does this by replaying one operation with only those lanes changed and comparing the two results.

// File: rtl/msched_pkg.sv
package msched_pkg;

   typedef enum logic {
      OP_EXPAND = 1'b0,
      OP_FINISH = 1'b1
   } msched_op_e;

   localparam int unsigned S0_ROT_A = 1;
   localparam int unsigned S0_ROT_B = 8;
   localparam int unsigned S0_SHR   = 7;
   localparam int unsigned S1_ROT_A = 19;
   localparam int unsigned S1_ROT_B = 61;
   localparam int unsigned S1_SHR   = 6;

   // Shift-based formulation, used only by the checks in the top module.
   function automatic logic [63:0] chk_rotr(input logic [63:0] x, input int unsigned n);
      int unsigned k;
      k = n % 64;
      if (k == 0) return x;
      return (x >> k) | (x << (64 - k));
   endfunction

   function automatic logic [63:0] chk_s0(input logic [63:0] x);
      return chk_rotr(x, S0_ROT_A) ^ chk_rotr(x, S0_ROT_B) ^ (x >> S0_SHR);
   endfunction

   function automatic logic [63:0] chk_s1(input logic [63:0] x);
      return chk_rotr(x, S1_ROT_A) ^ chk_rotr(x, S1_ROT_B) ^ (x >> S1_SHR);
   endfunction

endpackage

// File: rtl/msched_sigma.sv
module msched_sigma #(
   parameter int unsigned W     = 64,
   parameter int unsigned ROT_A = 1,
   parameter int unsigned ROT_B = 8,
   parameter int unsigned SHR_N = 7
) (
   input  logic [W-1:0] x,
   output logic [W-1:0] y
);
   localparam int unsigned RA = ROT_A % W;
   localparam int unsigned RB = ROT_B % W;

   if (W < 2) begin : g_bad_width
      $error("msched_sigma: W must be at least 2");
   end
   if (SHR_N >= W) begin : g_bad_shift
      $error("msched_sigma: SHR_N must be below W");
   end

   logic [2*W-1:0] doubled;
   logic [W-1:0]   rot_a;
   logic [W-1:0]   rot_b;
   logic [W-1:0]   shr_v;

   // Rotating by r is taking W bits from a doubled copy at offset r;
   // an offset of zero returns the word unchanged.
   assign doubled = {x, x};
   assign rot_a   = doubled[RA +: W];
   assign rot_b   = doubled[RB +: W];
   assign shr_v   = x >> SHR_N;
   assign y       = rot_a ^ rot_b ^ shr_v;

endmodule

// File: rtl/msched_expand.sv
module msched_expand #(
   parameter int unsigned LANE_W = 64,
   parameter int unsigned LANES  = 4
) (
   input  logic [LANES-1:0][LANE_W-1:0] a_l,
   input  logic [LANE_W-1:0]            b_low,
   output logic [LANES-1:0][LANE_W-1:0] sum_l
);
   import msched_pkg::*;

   if (LANES < 2) begin : g_bad_lanes
      $error("msched_expand: LANES must be at least 2");
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [LANE_W-1:0] nxt;
      logic [LANE_W-1:0] sig;
      if (i < LANES - 1) begin : g_inner
         assign nxt = a_l[i+1];
      end else begin : g_top
         assign nxt = b_low;
      end
      msched_sigma #(
         .W    (LANE_W),
         .ROT_A(S0_ROT_A),
         .ROT_B(S0_ROT_B),
         .SHR_N(S0_SHR)
      ) u_s0 (
         .x(nxt),
         .y(sig)
      );
      // Each lane has its own adder, so no carry crosses a lane edge.
      assign sum_l[i] = a_l[i] + sig;
   end

endmodule

// File: rtl/msched_finish.sv
module msched_finish #(
   parameter int unsigned LANE_W = 64,
   parameter int unsigned LANES  = 4
) (
   input  logic [LANES-1:0][LANE_W-1:0] a_l,
   input  logic [LANES-1:0][LANE_W-1:0] b_l,
   output logic [LANES-1:0][LANE_W-1:0] sum_l
);
   import msched_pkg::*;

   localparam int unsigned HALF = LANES / 2;

   if (LANES % 2 != 0) begin : g_bad_lanes
      $error("msched_finish: LANES must be even");
   end

   logic [HALF-1:0][LANE_W-1:0] lo_sum;

   for (genvar j = 0; j < HALF; j++) begin : g_pair
      logic [LANE_W-1:0] sig_lo;
      logic [LANE_W-1:0] sig_hi;

      // First link: sigma1 of an operand lane from the upper half of B.
      msched_sigma #(
         .W    (LANE_W),
         .ROT_A(S1_ROT_A),
         .ROT_B(S1_ROT_B),
         .SHR_N(S1_SHR)
      ) u_s1_lo (
         .x(b_l[j+HALF]),
         .y(sig_lo)
      );
      assign lo_sum[j] = a_l[j] + sig_lo;

      // Second link: sigma1 of the lane just computed.
      msched_sigma #(
         .W    (LANE_W),
         .ROT_A(S1_ROT_A),
         .ROT_B(S1_ROT_B),
         .SHR_N(S1_SHR)
      ) u_s1_hi (
         .x(lo_sum[j]),
         .y(sig_hi)
      );
      assign sum_l[j]      = lo_sum[j];
      assign sum_l[j+HALF] = a_l[j+HALF] + sig_hi;
   end

   logic unused_b_low;
   assign unused_b_low = ^b_l[HALF-1:0];

endmodule

// File: rtl/msched_top.sv
module msched_top #(
   parameter int unsigned LANE_W  = 64,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         in_valid,
   input  logic         op_sel,
   input  logic [255:0] opnd_a,
   input  logic [255:0] opnd_b,
   output logic         out_valid,
   output logic [255:0] result
);
   import msched_pkg::*;

   localparam int unsigned LANES = 4;
   localparam int unsigned VEC_W = LANES * LANE_W;

   if (LANE_W != 64) begin : g_bad_lane_w
      $error("msched_top: the sigma functions are defined for 64-bit lanes");
   end
   if (VEC_W != 256) begin : g_bad_vec_w
      $error("msched_top: lane packing must fill 256 bits");
   end

   logic [LANES-1:0][LANE_W-1:0] a_l;
   logic [LANES-1:0][LANE_W-1:0] b_l;
   logic [LANES-1:0][LANE_W-1:0] exp_l;
   logic [LANES-1:0][LANE_W-1:0] fin_l;
   logic [VEC_W-1:0]             comb_res;
   msched_op_e                   op;

   assign a_l = opnd_a;
   assign b_l = opnd_b;
   assign op  = msched_op_e'(op_sel);

   msched_expand #(.LANE_W(LANE_W), .LANES(LANES)) u_expand (
      .a_l  (a_l),
      .b_low(b_l[0]),
      .sum_l(exp_l)
   );

   msched_finish #(.LANE_W(LANE_W), .LANES(LANES)) u_finish (
      .a_l  (a_l),
      .b_l  (b_l),
      .sum_l(fin_l)
   );

   assign comb_res = (op == OP_FINISH) ? fin_l : exp_l;

   if (REG_OUT) begin : g_reg
      logic             vld_q;
      logic [VEC_W-1:0] res_q;

      always_ff @(posedge clk) begin
         if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
         end else begin
            vld_q <= in_valid;
            if (in_valid) res_q <= comb_res;
         end
      end

      assign out_valid = vld_q;
      assign result    = res_q;

      logic [LANES-1:0][LANE_W-1:0] r_l;
      assign r_l = res_q;

      assert_valid_R7: assert property (@(posedge clk) disable iff (rst)
         in_valid |=> out_valid);
      assert_idle_R7: assert property (@(posedge clk) disable iff (rst)
         !in_valid |=> !out_valid);
      assert_reset_R8: assert property (@(posedge clk)
         rst |=> (!out_valid && result == '0));
      assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
         !in_valid |=> $stable(result));
      assert_expand_lane0_R1: assert property (@(posedge clk) disable iff (rst)
         (in_valid && op_sel == 1'b0) |=>
         r_l[0] == $past(a_l[0]) + chk_s0($past(a_l[1])));
      assert_expand_lane3_R2: assert property (@(posedge clk) disable iff (rst)
         (in_valid && op_sel == 1'b0) |=>
         r_l[3] == $past(a_l[3]) + chk_s0($past(b_l[0])));
      assert_finish_lane1_R3: assert property (@(posedge clk) disable iff (rst)
         (in_valid && op_sel == 1'b1) |=>
         r_l[1] == $past(a_l[1]) + chk_s1($past(b_l[3])));
      assert_finish_chain_R4: assert property (@(posedge clk) disable iff (rst)
         (in_valid && op_sel == 1'b1) |=>
         r_l[2] == $past(a_l[2]) + chk_s1(r_l[0]));
   end else begin : g_comb
      assign out_valid = in_valid;
      assign result    = comb_res;
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst;
   end

endmodule

// File: tb/sim_msched_top.sv
module sim_msched_top;

   logic         clk = 1'b0;
   logic         rst;
   logic         in_valid;
   logic         op_sel;
   logic [255:0] opnd_a;
   logic [255:0] opnd_b;
   logic         out_valid;
   logic [255:0] result;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   msched_top u0 (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid),
      .op_sel   (op_sel),
      .opnd_a   (opnd_a),
      .opnd_b   (opnd_b),
      .out_valid(out_valid),
      .result   (result)
   );

   // Bit-by-bit model of the requirements.
   function automatic logic [63:0] m_rotr(input logic [63:0] x, input int n);
      logic [63:0] r;
      for (int k = 0; k < 64; k++) r[k] = x[(k + n) % 64];
      return r;
   endfunction
   function automatic logic [63:0] m_s0(input logic [63:0] x);
      return m_rotr(x, 1) ^ m_rotr(x, 8) ^ (x >> 7);
   endfunction
   function automatic logic [63:0] m_s1(input logic [63:0] x);
      return m_rotr(x, 19) ^ m_rotr(x, 61) ^ (x >> 6);
   endfunction
   function automatic logic [63:0] ln(input logic [255:0] v, input int i);
      return v[64*i +: 64];
   endfunction
   function automatic logic [255:0] model(input logic op, input logic [255:0] a,
                                          input logic [255:0] b);
      logic [63:0] r [4];
      if (!op) begin
         for (int i = 0; i < 3; i++) r[i] = ln(a, i) + m_s0(ln(a, i + 1));
         r[3] = ln(a, 3) + m_s0(ln(b, 0));
      end else begin
         r[0] = ln(a, 0) + m_s1(ln(b, 2));
         r[1] = ln(a, 1) + m_s1(ln(b, 3));
         r[2] = ln(a, 2) + m_s1(r[0]);
         r[3] = ln(a, 3) + m_s1(r[1]);
      end
      return {r[3], r[2], r[1], r[0]};
   endfunction

   task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Drive one operation for a single cycle; returns at the next falling edge,
   // one rising edge after capture.
   task automatic apply(input logic op, input logic [255:0] a, input logic [255:0] b);
      @(negedge clk);
      in_valid = 1'b1;
      op_sel   = op;
      opnd_a   = a;
      opnd_b   = b;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic check_lanes(input logic op, input logic [255:0] exp);
      for (int i = 0; i < 4; i++) begin
         if (!op) check64((i < 3) ? "R1 expand lane" : "R2 expand lane3", ln(result, i), ln(exp, i));
         else     check64((i < 2) ? "R3 finish low lane" : "R4 finish chained lane", ln(result, i), ln(exp, i));
      end
   endtask

   // {op, A lanes 3..0, B lanes 3..0}
   localparam int NV = 6;
   localparam logic [512:0] VEC [NV] = '{
      {1'b0, 64'h0000000000000004, 64'h0000000000000003, 64'h0000000000000002, 64'h0000000000000001,
             64'h0000000000000000, 64'h0000000000000000, 64'h0000000000000000, 64'h0000000000000005},
      {1'b0, 64'h0123456789ABCDEF, 64'hFEDCBA9876543210, 64'hDEADBEEFCAFEF00D, 64'h8000000000000001,
             64'h1111111111111111, 64'h2222222222222222, 64'h3333333333333333, 64'hA5A5A5A55A5A5A5A},
      {1'b0, 64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF,
             64'h0, 64'h0, 64'h0, 64'hFFFFFFFFFFFFFFFF},
      {1'b1, 64'h0000000000000000, 64'h0000000000000000, 64'h0000000000000000, 64'h0000000000000000,
             64'h0000000000000001, 64'h8000000000000000, 64'h0, 64'h0},
      {1'b1, 64'h6A09E667F3BCC908, 64'hBB67AE8584CAA73B, 64'h3C6EF372FE94F82B, 64'hA54FF53A5F1D36F1,
             64'h510E527FADE682D1, 64'h9B05688C2B3E6C1F, 64'h1F83D9ABFB41BD6B, 64'h5BE0CD19137E2179},
      {1'b1, 64'hFFFFFFFFFFFFFFFF, 64'h00000000FFFFFFFF, 64'hFFFFFFFF00000000, 64'h5555555555555555,
             64'hAAAAAAAAAAAAAAAA, 64'hCCCCCCCCCCCCCCCC, 64'h0F0F0F0F0F0F0F0F, 64'hF0F0F0F0F0F0F0F0}
   };

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : main
      logic [255:0] held;
      logic [255:0] first;
      rst = 1'b1; in_valid = 1'b0; op_sel = 1'b0; opnd_a = '0; opnd_b = '0;
      repeat (3) @(negedge clk);
      // R8: reset state
      check64("R8 reset out_valid", {63'd0, out_valid}, 64'd0);
      check64("R8 reset result lane0", ln(result, 0), 64'd0);
      rst = 1'b0;

      // Vector table walk
      for (int v = 0; v < NV; v++) begin
         apply(VEC[v][512], VEC[v][511:256], VEC[v][255:0]);
         check64("R7 out_valid after accept", {63'd0, out_valid}, 64'd1);
         check_lanes(VEC[v][512], model(VEC[v][512], VEC[v][511:256], VEC[v][255:0]));
      end

      // R4: hand-derived chain value, two rotated copies cancel
      apply(1'b1, 256'd0, {64'd0, 64'd1, 64'd0, 64'd0});
      check64("R3 finish lane0 hand", ln(result, 0), 64'h0000200000000008);
      check64("R4 finish lane2 hand", ln(result, 2), 64'h0000008004000040);

      // R6: lane 0 wraps; lane 1 gets no carry
      apply(1'b0, {64'd0, 64'd0, 64'd1, 64'hFFFFFFFFFFFFFFFF}, 256'd0);
      check64("R6 wrap lane0", ln(result, 0), 64'h80FFFFFFFFFFFFFF);
      check64("R6 no carry lane1", ln(result, 1), 64'd1);

      // R2: B lanes 1..3 ignored in expand
      apply(1'b0, VEC[1][511:256], {64'd0, 64'd0, 64'd0, 64'h77});
      first = result;
      apply(1'b0, VEC[1][511:256], {64'hFFFF0000FFFF0000, 64'h1234, 64'hFEFE, 64'h77});
      for (int i = 0; i < 4; i++) check64("R2 ignored B lanes", ln(result, i), ln(first, i));

      // R5: B lanes 0..1 ignored in finish
      apply(1'b1, VEC[4][511:256], {64'h9, 64'h8, 64'd0, 64'd0});
      first = result;
      apply(1'b1, VEC[4][511:256], {64'h9, 64'h8, 64'hDEADDEADDEADDEAD, 64'hBEEF});
      for (int i = 0; i < 4; i++) check64("R5 ignored B lanes", ln(result, i), ln(first, i));

      // R7: out_valid drops after one cycle; R9: result held while idle
      held = result;
      @(negedge clk);
      opnd_a = ~opnd_a; opnd_b = ~opnd_b; op_sel = ~op_sel;
      check64("R7 out_valid low when idle", {63'd0, out_valid}, 64'd0);
      repeat (2) @(negedge clk);
      check64("R9 held lane0", ln(result, 0), ln(held, 0));
      check64("R9 held lane3", ln(result, 3), ln(held, 3));

      // R8: reset in mid-run
      apply(1'b0, VEC[1][511:256], VEC[1][255:0]);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check64("R8 mid reset out_valid", {63'd0, out_valid}, 64'd0);
      check64("R8 mid reset result lane1", ln(result, 1), 64'd0);
      rst = 1'b0;

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule